// File: doc/BRIEF.md
# Externally Clocked Serial Word Receiver

This block takes 32-bit words from a three-wire synchronous serial link: a bit clock that the sender drives, an active-low frame-sync line and a data line. All three lines are resynchronised into the system-clock domain. Falling edges of the bit clock are detected there, and each one acts as a sampling strobe. A frame begins when a falling edge finds frame sync newly low. After a start offset of 0, 1 or 2 bit periods, 32 data bits follow, most significant bit first. The offset is loaded when the block is initialised.

A word becomes visible only after one more falling edge of the bit clock that follows its last bit. That same edge may already carry the frame sync of the next word. Completed words are offered on a valid/ready output. If an unread word is overwritten, a sticky overrun flag is set. After reset and after every init pulse, the first frame is received but thrown away. The system clock must run several times faster than the bit clock; 16 MHz is the highest bit rate intended.

Top module: `ser_word_rx`

## Requirements
- R1: Data is sampled at falling edges of the bit clock. Exactly 32 bits make a word, and the first bit sampled becomes bit 31 of `word_o`.
- R2: `init_i` loads the start offset from `init_delay_i`. The value 0 takes bit 31 on the edge that detects frame sync, 1 takes it one falling edge later and 2 takes it two falling edges later. The value 3 acts as 2. After reset the offset is 1.
- R3: A frame starts only at a falling edge where frame sync is low and was high at the previous falling edge. How long frame sync stays low has no effect.
- R4: A word is committed, and `word_valid_o` rises, only at the next falling edge after its bit 0 was sampled.
- R5: A frame start on the committing edge begins the next word while the previous word is still delivered, so words sent back to back are all received.
- R6: The first frame after reset or after an `init_i` pulse is never presented on the output.
- R7: A frame start during a word in progress drops the partial word and starts a new one.
- R8: If a word commits while `word_valid_o` is high and `word_ready_i` is low, the new word replaces the old one and `overrun_o` is set. The flag is cleared only by reset or `init_i`.
- R9: While `word_valid_o` is high and `word_ready_i` is low, the valid flag stays high and `word_o` holds unless a new word commits. After reset, `word_valid_o`, `overrun_o` and `word_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Init pulse: loads the offset, clears overrun and re-arms the first-frame drop |
| init_delay_i | input | 2 | Start offset in bit periods, taken when `init_i` is high |
| ser_clk_i | input | 1 | Serial bit clock from the sender |
| ser_fs_n_i | input | 1 | Serial frame sync, active low |
| ser_dat_i | input | 1 | Serial data, changed by the sender on rising edges |
| word_o | output | 32 | Received word |
| word_valid_o | output | 1 | Received word is available |
| word_ready_i | input | 1 | Consumer takes the word |
| overrun_o | output | 1 | Sticky flag: an unread word was overwritten |

## Verification
Words are sent with all ones, all zeros, alternating bits and the two end bits set alone. Together these separate bit-order errors, stuck data and off-by-one shifts. The same words are sent with each start offset, with a frame sync held low for several periods, and back to back with the next frame sync on the committing edge. These runs show whether the offset count, the edge-only start and the shared commit/start edge are right. Further tests cover a truncated word followed by a full one, a word left without its extra clock edge, and the first frame after init. They show whether aborts, commit timing and the discard rule each take effect. Holding ready low across two words checks overwrite and the sticky flag.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int DLY_MAX = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_COMMIT
    } rx_state_e;

    function automatic logic [1:0] clamp_delay(input logic [1:0] raw);
        return (int'(raw) > DLY_MAX) ? 2'(DLY_MAX) : raw;
    endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_edge.sv
module srx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [1:0]        init_delay_i,
    input  logic              fall_i,
    input  logic              fs_n_i,
    input  logic              dat_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  bitcnt_o,
    output logic [1:0]        dly_o
);
    typedef struct packed {
        rx_state_e         state;
        logic [1:0]        dly;
        logic [1:0]        wait_cnt;
        logic [CNT_W-1:0]  bitcnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              fs_last;
        logic              armed;
        logic              discard;
        logic              commit;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   start;

    always_comb begin
        fr_d        = fr_q;
        fr_d.commit = 1'b0;
        start       = 1'b0;
        if (init_i) begin
            fr_d.state   = ST_IDLE;
            fr_d.dly     = clamp_delay(init_delay_i);
            fr_d.armed   = 1'b0;
            fr_d.fs_last = 1'b1;
            fr_d.bitcnt  = '0;
        end else if (fall_i) begin
            fr_d.fs_last = fs_n_i;
            start        = ~fs_n_i & fr_q.fs_last;
            if (fr_q.state == ST_COMMIT) begin
                fr_d.state = ST_IDLE;
                if (!fr_q.discard) begin
                    fr_d.commit = 1'b1;
                    fr_d.word   = fr_q.shreg;
                end
            end
            if (start) begin
                fr_d.discard = ~fr_q.armed;
                fr_d.armed   = 1'b1;
                fr_d.bitcnt  = '0;
                if (fr_q.dly == 2'd0) begin
                    fr_d.shreg  = {fr_q.shreg[WORD_W-2:0], dat_i};
                    fr_d.bitcnt = CNT_W'(1);
                    fr_d.state  = ST_SHIFT;
                end else begin
                    fr_d.wait_cnt = fr_q.dly - 2'd1;
                    fr_d.state    = ST_WAIT;
                end
            end else begin
                case (fr_q.state)
                    ST_WAIT: begin
                        if (fr_q.wait_cnt == 2'd0) begin
                            fr_d.shreg  = {fr_q.shreg[WORD_W-2:0], dat_i};
                            fr_d.bitcnt = CNT_W'(1);
                            fr_d.state  = ST_SHIFT;
                        end else begin
                            fr_d.wait_cnt = fr_q.wait_cnt - 2'd1;
                        end
                    end
                    ST_SHIFT: begin
                        fr_d.shreg  = {fr_q.shreg[WORD_W-2:0], dat_i};
                        fr_d.bitcnt = fr_q.bitcnt + CNT_W'(1);
                        if (fr_q.bitcnt == CNT_W'(WORD_W - 1)) begin
                            fr_d.state = ST_COMMIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q         <= '0;
            fr_q.state   <= ST_IDLE;
            fr_q.dly     <= 2'd1;
            fr_q.fs_last <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign commit_o = fr_q.commit;
    assign word_o   = fr_q.word;
    assign bitcnt_o = fr_q.bitcnt;
    assign dly_o    = fr_q.dly;
endmodule

// File: rtl/srx_out.sv
module srx_out
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ready_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              overrun_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              overrun;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (out_q.valid && ready_i) begin
            out_d.valid = 1'b0;
        end
        if (commit_i) begin
            if (out_q.valid && !ready_i) begin
                out_d.overrun = 1'b1;
            end
            out_d.word  = word_i;
            out_d.valid = 1'b1;
        end
        if (init_i) begin
            out_d.overrun = 1'b0;
            out_d.valid   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o    = out_q.word;
    assign valid_o   = out_q.valid;
    assign overrun_o = out_q.overrun;
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [1:0]        init_delay_i,
    input  logic              ser_clk_i,
    input  logic              ser_fs_n_i,
    input  logic              ser_dat_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    input  logic              word_ready_i,
    output logic              overrun_o
);
    logic [2:0]        sync_w;
    logic              fall_w;
    logic              commit_w;
    logic [WORD_W-1:0] cword_w;
    logic [CNT_W-1:0]  bitcnt_w;
    logic [1:0]        dly_w;

    srx_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dat_i, ser_fs_n_i, ser_clk_i}),
        .sync_o  (sync_w)
    );

    srx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_w[0]),
        .fall_o  (fall_w)
    );

    srx_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .init_delay_i (init_delay_i),
        .fall_i       (fall_w),
        .fs_n_i       (sync_w[1]),
        .dat_i        (sync_w[2]),
        .commit_o     (commit_w),
        .word_o       (cword_w),
        .bitcnt_o     (bitcnt_w),
        .dly_o        (dly_w)
    );

    srx_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .commit_i  (commit_w),
        .word_i    (cword_w),
        .ready_i   (word_ready_i),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .overrun_o (overrun_o)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              init,
    input logic              fall,
    input logic [CNT_W-1:0]  bitcnt,
    input logic [1:0]        dly,
    input logic              commit,
    input logic              valid,
    input logic              ready,
    input logic [WORD_W-1:0] word,
    input logic              overrun
);
    AST_CNT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !init) |=> $stable(bitcnt)); // R1

    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dly) <= DLY_MAX); // R2

    AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(fall)); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || init)
        overrun |=> overrun); // R8

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(commit && valid && !ready)); // R8

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n || init)
        (valid && !ready) |=> valid); // R9

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !commit) |=> $stable(word)); // R9
endmodule

bind ser_word_rx srx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init_i),
    .fall    (fall_w),
    .bitcnt  (bitcnt_w),
    .dly     (dly_w),
    .commit  (commit_w),
    .valid   (word_valid_o),
    .ready   (word_ready_i),
    .word    (word_o),
    .overrun (overrun_o)
);

// File: tb/ser_word_rx_test.sv
`timescale 1ns/1ps
module ser_word_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic [1:0]  init_delay_i = 2'd1;
    logic        ser_clk_i = 1'b1;
    logic        ser_fs_n_i = 1'b1;
    logic        ser_dat_i = 1'b0;
    logic [31:0] word_o;
    logic        word_valid_o;
    logic        word_ready_i = 1'b1;
    logic        overrun_o;

    int tests = 0;
    int fails = 0;
    int cur_dly = 1;
    logic [31:0] exp_q[$];

    ser_word_rx uut (.*);

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected words as the design hands them over
    always @(negedge clk) begin
        if (rst_n && word_valid_o && word_ready_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected word", word_o, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(word_o == e, "R1 word", word_o, e);
            end
        end
    end

    task automatic bit_period(input logic fs, input logic d);
        ser_clk_i  = 1'b1;
        ser_fs_n_i = fs;
        ser_dat_i  = d;
        #32;
        ser_clk_i = 1'b0;
        #32;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bit_period(1'b1, 1'b0);
    endtask

    // drives frame sync for fs_w periods, then nbits data bits after cur_dly
    task automatic frame(input logic [31:0] w, input int fs_w, input int nbits, input bit push);
        if (push) exp_q.push_back(w);
        for (int p = 0; p < cur_dly + nbits; p++) begin
            bit_period((p < fs_w) ? 1'b0 : 1'b1,
                       (p >= cur_dly) ? w[31 - (p - cur_dly)] : 1'b0);
        end
    endtask

    task automatic do_init(input logic [1:0] d, input int model);
        @(posedge clk); #1;
        init_i = 1'b1;
        init_delay_i = d;
        @(posedge clk); #1;
        init_i = 1'b0;
        cur_dly = model;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(posedge clk);
            t++;
        end
        check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(word_valid_o == 1'b0, "R9 reset valid", 32'(word_valid_o), 32'h0);
        check(overrun_o == 1'b0, "R9 reset overrun", 32'(overrun_o), 32'h0);
        check(word_o == 32'h0, "R9 reset word", word_o, 32'h0);

        // R6: first frame after reset is dropped (default offset 1, R2)
        idle(2);
        frame(32'h5555_AAAA, 1, 32, 1'b0);
        idle(2);
        repeat (20) @(negedge clk);
        check(word_valid_o == 1'b0, "R6 first frame dropped", 32'(word_valid_o), 32'h0);

        // R4: no commit without the extra edge
        frame(32'hFFFF_FFFF, 1, 32, 1'b1);
        repeat (30) @(negedge clk);
        check(word_valid_o == 1'b0 && exp_q.size() == 1, "R4 needs extra edge",
              32'(word_valid_o), 32'h0);
        idle(1);
        drain("R4 commit after extra edge");

        // R1: distinct patterns
        frame(32'h0000_0000, 1, 32, 1'b1); idle(1);
        frame(32'hAAAA_AAAA, 1, 32, 1'b1); idle(1);
        frame(32'h8000_0001, 1, 32, 1'b1); idle(2);
        drain("R1 patterns");

        // R5: back-to-back, next frame sync on the committing edge
        frame(32'h1357_9BDF, 1, 32, 1'b1);
        frame(32'h2468_ACE0, 1, 32, 1'b1);
        frame(32'hF0E1_D2C3, 1, 32, 1'b1);
        idle(1);
        drain("R5 back to back");

        // R3: long frame sync
        frame(32'h1234_5678, 3, 32, 1'b1); idle(1);
        drain("R3 long frame sync");

        // R7: abort partial word
        frame(32'hDEAD_0000, 1, 10, 1'b0);
        frame(32'h0BAD_F00D, 1, 32, 1'b1); idle(1);
        drain("R7 abort restart");

        // R2: offset 0
        do_init(2'd0, 0);
        idle(1);
        frame(32'h7777_0000, 1, 32, 1'b0); idle(1);
        frame(32'hC001_D00D, 2, 32, 1'b1); idle(1);
        drain("R2 offset 0");

        // R2: offset 2
        do_init(2'd2, 2);
        frame(32'h0000_7777, 1, 32, 1'b0); idle(1);
        frame(32'hC3C3_5A5A, 1, 32, 1'b1); idle(1);
        drain("R2 offset 2");

        // R2: value 3 acts as 2
        do_init(2'd3, 2);
        frame(32'h1111_1111, 1, 32, 1'b0); idle(1);
        frame(32'h8421_1248, 1, 32, 1'b1); idle(1);
        drain("R2 offset 3 clamps");

        // R8: overrun
        do_init(2'd1, 1);
        frame(32'h9999_9999, 1, 32, 1'b0); idle(1);
        @(posedge clk); #1 word_ready_i = 1'b0;
        frame(32'hAAAA_0001, 1, 32, 1'b0); idle(1);
        frame(32'hBBBB_0002, 1, 32, 1'b1); idle(1);
        repeat (20) @(negedge clk);
        check(overrun_o == 1'b1, "R8 overrun set", 32'(overrun_o), 32'h1);
        check(word_o == 32'hBBBB_0002, "R8 overwrite", word_o, 32'hBBBB_0002);
        check(word_valid_o == 1'b1, "R9 valid held", 32'(word_valid_o), 32'h1);
        @(posedge clk); #1 word_ready_i = 1'b1;
        drain("R8 new word delivered");
        repeat (4) @(negedge clk);
        check(overrun_o == 1'b1, "R8 sticky", 32'(overrun_o), 32'h1);
        do_init(2'd1, 1);
        @(negedge clk);
        check(overrun_o == 1'b0, "R8 cleared by init", 32'(overrun_o), 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule